// File: doc/BRIEF.md
# Class-D Output Stage Protection Controller

This block decides when a four-half-bridge class-D power stage may switch. It watches supervisor flags that arrive from analog comparators: temperature warning set and release, over-temperature error, overcurrent, and undervoltage on two gate-drive rails and the logic rail. It also watches an active-low device reset pin and a two-bit configuration strap. From these inputs it drives a released/pulled fault line, a temperature warning line, one high-impedance enable per half-bridge, a weak-pulldown enable and a run enable.

Faults come in two kinds. Over-temperature error and overcurrent are sticky: they stay in force until the device reset pin is driven low. Undervoltage clears itself once every monitored rail has recovered. While the device reset pin is low, the outputs float and the fault line is released. In the bridge-tied configurations the weak pulldowns also switch on, so that the bootstrap capacitors can charge. Every asynchronous input, the strap included, passes through a synchronizer before any logic sees it.

Top module: `pstg_protect_ctrl`

## Requirements
- R1: During system reset (`rst_n` low) and just after it, `hiz_o` is all ones, `run_o` is 0, `pd_en_o` is 0, `fault_rel_o` is 1 and `warn_o` is 0.
- R2: A change on any flag input, on `dev_rst_n_i` or on `mode_i` reaches the outputs on the third rising clock edge after it is applied, and not on an earlier edge.
- R3: When a shutdown is in force and `dev_rst_n_i` is high, every bit of `hiz_o` is 1, `run_o` is 0 and `fault_rel_o` is 0. This holds in every mode.
- R4: A pulse on `ot_err_i` causes a shutdown that persists after the flag drops. Only a low level on `dev_rst_n_i` clears it.
- R5: A pulse on `oc_i` causes a shutdown that persists after the flag drops. Only a low level on `dev_rst_n_i` clears it.
- R6: Any bit of `uv_i` (bit 0 and bit 1 are the gate-drive rails, bit 2 is the logic rail) causes a shutdown. Once all bits are low again, normal operation resumes without a device reset.
- R7: While `dev_rst_n_i` is low, `fault_rel_o` is 1, `hiz_o` is all ones and `run_o` is 0, whatever flags are present. Sticky faults are ignored during this time.
- R8: `pd_en_o` is 1 exactly when the outputs are not running and `mode_i` is 00 (bridge-tied, two lines per channel) or 01 (bridge-tied, one line per channel). It is never 1 in mode 10 (four single-ended channels) or mode 11.
- R9: Mode 11 is reserved and acts as a permanent shutdown: `fault_rel_o` is 0 and all outputs float, for as long as the strap stays 11 and the device reset is high.
- R10: `warn_o` sets when `ot_warn_i` is high. It stays set until `ot_warn_clr_i` is high while `ot_warn_i` is low. Setting wins over clearing.
- R11: `warn_o` does not depend on the device reset or on shutdown. The pair `fault_rel_o`/`warn_o` reads 1/0 for normal operation, 1/1 for warning only, and 0/x for a shutdown fault.
- R12: `run_o` is 1, `hiz_o` is all zeros and `pd_en_o` is 0 exactly when `dev_rst_n_i` is high and no shutdown is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| dev_rst_n_i | input | 1 | Active-low device reset pin, asynchronous |
| mode_i | input | 2 | Configuration strap: 00 / 01 bridge-tied, 10 single-ended, 11 reserved |
| ot_warn_i | input | 1 | Temperature above warning threshold |
| ot_warn_clr_i | input | 1 | Temperature has fallen by the hysteresis amount |
| ot_err_i | input | 1 | Over-temperature error flag |
| oc_i | input | 1 | Overcurrent flag |
| uv_i | input | NUM_UV (3) | Undervoltage flags: [0] gate rail A/B, [1] gate rail C/D, [2] logic rail |
| fault_rel_o | output | 1 | Open-drain fault control: 1 releases the line, 0 pulls it low |
| warn_o | output | 1 | Temperature warning, active high |
| hiz_o | output | NUM_HB (4) | High-impedance enable for each half-bridge |
| pd_en_o | output | 1 | Weak output pulldown enable |
| run_o | output | 1 | PWM switching permitted |

## Verification
The bench uses the default build: four half-bridges, three rail flags and two synchronizer stages. The small flag space lets it sweep every strap code against every undervoltage combination, once with the device reset high and once with it low, and compare each result with a model it computes itself. With only two synchronizer stages, the three-edge latency can be checked edge by edge. Directed sequences then cover sticky-fault pulses and their clearing by reset, faults raised during reset, and the set, hold and release behaviour of the warning.

// File: rtl/pstg_pkg.sv
package pstg_pkg;

  typedef enum logic [1:0] {
    MODE_BTL_DUAL   = 2'b00,
    MODE_BTL_SINGLE = 2'b01,
    MODE_SE_QUAD    = 2'b10,
    MODE_RESERVED   = 2'b11
  } stage_mode_e;

  function automatic logic mode_is_bridge(stage_mode_e m);
    return (m == MODE_BTL_DUAL) || (m == MODE_BTL_SINGLE);
  endfunction

endpackage

// File: rtl/pstg_sync_bank.sv
module pstg_sync_bank #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pstg_fault_core.sv
module pstg_fault_core
  import pstg_pkg::*;
#(
  parameter int NUM_UV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  stage_mode_e       mode_i,
  input  logic              ot_err_i,
  input  logic              oc_i,
  input  logic [NUM_UV-1:0] uv_i,
  input  logic              warn_set_i,
  input  logic              warn_clr_i,
  output logic              shutdown_o,
  output logic              warn_o
);
  logic ote_lat_q, oc_lat_q, warn_q;
  logic uv_any, sticky_any, rsvd;

  assign uv_any     = |uv_i;
  assign rsvd       = (mode_i == MODE_RESERVED);
  assign sticky_any = ote_lat_q | ot_err_i | oc_lat_q | oc_i;
  assign shutdown_o = !hold_i && (sticky_any || uv_any || rsvd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ote_lat_q <= 1'b0;
      oc_lat_q  <= 1'b0;
    end else if (hold_i) begin
      ote_lat_q <= 1'b0;
      oc_lat_q  <= 1'b0;
    end else begin
      ote_lat_q <= ote_lat_q | ot_err_i;
      oc_lat_q  <= oc_lat_q | oc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warn_q <= 1'b0;
    else if (warn_set_i) warn_q <= 1'b1;
    else if (warn_clr_i) warn_q <= 1'b0;
  end

  assign warn_o = warn_q;

  a_r4_ote_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && (ote_lat_q || ot_err_i)) |=> (shutdown_o || hold_i));
  a_r5_oc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && (oc_lat_q || oc_i)) |=> (shutdown_o || hold_i));
  a_r6_uv_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && uv_any) |-> shutdown_o);
  a_r7_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!ote_lat_q && !oc_lat_q));
  a_r10_warn_set: assert property (@(posedge clk) disable iff (!rst_n)
    warn_set_i |=> warn_o);
  a_r10_warn_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_o && !warn_clr_i) |=> warn_o);
endmodule

// File: rtl/pstg_drive_stage.sv
module pstg_drive_stage #(
  parameter int NUM_HB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              shutdown_i,
  input  logic              bridge_i,
  output logic              fault_rel_o,
  output logic              run_o,
  output logic [NUM_HB-1:0] hiz_o,
  output logic              pd_en_o
);
  logic fault_rel_q, run_q, pd_q;
  logic [NUM_HB-1:0] hiz_q;
  logic run_d;

  assign run_d = !hold_i && !shutdown_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_rel_q <= 1'b1;
      run_q       <= 1'b0;
      pd_q        <= 1'b0;
    end else begin
      fault_rel_q <= hold_i || !shutdown_i;
      run_q       <= run_d;
      pd_q        <= !run_d && bridge_i;
    end
  end

  for (genvar g = 0; g < NUM_HB; g++) begin : g_hb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hiz_q[g] <= 1'b1;
      else        hiz_q[g] <= !run_d;
    end
  end

  assign fault_rel_o = fault_rel_q;
  assign run_o       = run_q;
  assign hiz_o       = hiz_q;
  assign pd_en_o     = pd_q;

  a_r3_shutdown_float: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_i && !hold_i) |=> (!fault_rel_o && hiz_o == '1 && !run_o));
  a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (fault_rel_o && hiz_o == '1 && !run_o));
  a_r8_no_pd_single_ended: assert property (@(posedge clk) disable iff (!rst_n)
    !bridge_i |=> !pd_en_o);
  a_r12_run_drives: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (hiz_o == '0 && !pd_en_o && fault_rel_o));
endmodule

// File: rtl/pstg_protect_ctrl.sv
module pstg_protect_ctrl
  import pstg_pkg::*;
#(
  parameter int NUM_HB      = 4,
  parameter int NUM_UV      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst_n_i,
  input  logic [1:0]        mode_i,
  input  logic              ot_warn_i,
  input  logic              ot_warn_clr_i,
  input  logic              ot_err_i,
  input  logic              oc_i,
  input  logic [NUM_UV-1:0] uv_i,
  output logic              fault_rel_o,
  output logic              warn_o,
  output logic [NUM_HB-1:0] hiz_o,
  output logic              pd_en_o,
  output logic              run_o
);
  localparam int FLAG_W = NUM_UV + 7;

  logic [FLAG_W-1:0] raw_flags, s_flags;
  logic              s_dev_rst_n, s_warn, s_warn_clr, s_ote, s_oc;
  logic [1:0]        s_mode;
  logic [NUM_UV-1:0] s_uv;
  stage_mode_e       mode_e;
  logic              hold, shutdown;

  assign raw_flags = {dev_rst_n_i, mode_i, ot_warn_i, ot_warn_clr_i, ot_err_i, oc_i, uv_i};

  pstg_sync_bank #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_flags),
    .q_o   (s_flags)
  );

  assign {s_dev_rst_n, s_mode, s_warn, s_warn_clr, s_ote, s_oc, s_uv} = s_flags;
  assign mode_e = stage_mode_e'(s_mode);
  assign hold   = !s_dev_rst_n;

  pstg_fault_core #(.NUM_UV(NUM_UV)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_i     (hold),
    .mode_i     (mode_e),
    .ot_err_i   (s_ote),
    .oc_i       (s_oc),
    .uv_i       (s_uv),
    .warn_set_i (s_warn),
    .warn_clr_i (s_warn_clr),
    .shutdown_o (shutdown),
    .warn_o     (warn_o)
  );

  pstg_drive_stage #(.NUM_HB(NUM_HB)) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (hold),
    .shutdown_i  (shutdown),
    .bridge_i    (mode_is_bridge(mode_e)),
    .fault_rel_o (fault_rel_o),
    .run_o       (run_o),
    .hiz_o       (hiz_o),
    .pd_en_o     (pd_en_o)
  );

  a_r9_reserved_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MODE_RESERVED && !hold) |=> (!fault_rel_o && !run_o && !pd_en_o));
endmodule

// File: tb/test_pstg_protect_ctrl.sv
module test_pstg_protect_ctrl;
  localparam int NUM_HB = 4;
  localparam int NUM_UV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ot_warn = 1'b0, ot_warn_clr = 1'b0, ot_err = 1'b0, oc = 1'b0;
  logic [NUM_UV-1:0] uv = '0;
  logic fault_rel, warn, pd_en, run;
  logic [NUM_HB-1:0] hiz;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pstg_protect_ctrl #(.NUM_HB(NUM_HB), .NUM_UV(NUM_UV), .SYNC_STAGES(2)) i_pstg_protect_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_rst_n_i(dev_rst_n), .mode_i(mode),
    .ot_warn_i(ot_warn), .ot_warn_clr_i(ot_warn_clr), .ot_err_i(ot_err), .oc_i(oc),
    .uv_i(uv), .fault_rel_o(fault_rel), .warn_o(warn), .hiz_o(hiz),
    .pd_en_o(pd_en), .run_o(run)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic to_negedge();
    @(negedge clk);
  endtask

  // Expected outputs from requirement terms
  task automatic check_model(string req, bit hold, logic [1:0] m, bit sticky, bit uv_any);
    bit sd, rn, rel, pd;
    sd  = !hold && (sticky || uv_any || (m == 2'b11));
    rn  = !hold && !sd;
    rel = hold || !sd;
    pd  = !rn && (m == 2'b00 || m == 2'b01);
    check(req, "run_o", run, rn);
    check(req, "fault_rel_o", fault_rel, rel);
    check(req, "hiz_o", hiz, rn ? 0 : {NUM_HB{1'b1}});
    check(req, "pd_en_o", pd_en, pd);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "hiz_o", hiz, {NUM_HB{1'b1}});
    check("R1", "run_o", run, 0);
    check("R1", "pd_en_o", pd_en, 0);
    check("R1", "fault_rel_o", fault_rel, 1);
    check("R1", "warn_o", warn, 0);
    to_negedge();
    dev_rst_n = 1'b1;
    rst_n = 1'b1;
    settle();
    check_model("R12", 0, 2'b00, 0, 0);

    // R2 latency: three edges exactly
    to_negedge();
    uv = 3'b001;
    repeat (2) @(posedge clk);
    #1 check("R2", "run_o before third edge", run, 1);
    @(posedge clk);
    #1 check("R2", "run_o at third edge", run, 0);
    to_negedge();
    uv = '0;
    settle();

    // R3 R6 R8 R9 R12: sweep strap x rail flags with device reset high
    for (int m = 0; m < 4; m++) begin
      for (int u = 0; u < 8; u++) begin
        to_negedge();
        mode = m[1:0];
        uv = u[2:0];
        settle();
        check_model((u != 0) ? "R6" : ((m == 3) ? "R9" : "R12"), 0, m[1:0], 0, u != 0);
        if (u != 0 || m == 3) check("R3", "shutdown fault_rel_o", fault_rel, 0);
        if (m >= 2) check("R8", "no pulldown", pd_en, 0);
      end
    end
    // R6 recovery without reset
    to_negedge();
    mode = 2'b01;
    uv = '0;
    settle();
    check("R6", "run_o after recovery", run, 1);

    // R7 R8: sweep with device reset low, sticky flags also present
    to_negedge();
    dev_rst_n = 1'b0;
    ot_err = 1'b1;
    oc = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int u = 0; u < 8; u++) begin
        to_negedge();
        mode = m[1:0];
        uv = u[2:0];
        settle();
        check_model("R7", 1, m[1:0], 1, u != 0);
        check("R8", "pd_en_o in hold", pd_en, m < 2);
      end
    end
    // R7 sticky flags raised during reset are ignored after release
    to_negedge();
    ot_err = 1'b0;
    oc = 1'b0;
    uv = '0;
    mode = 2'b00;
    settle();
    to_negedge();
    dev_rst_n = 1'b1;
    settle();
    check("R7", "run_o after release", run, 1);

    // R4 over-temperature error is sticky
    to_negedge();
    ot_err = 1'b1;
    settle();
    to_negedge();
    ot_err = 1'b0;
    repeat (10) @(posedge clk);
    #1 check_model("R4", 0, 2'b00, 1, 0);
    to_negedge();
    dev_rst_n = 1'b0;
    settle();
    to_negedge();
    dev_rst_n = 1'b1;
    settle();
    check("R4", "run_o after reset pulse", run, 1);

    // R5 overcurrent is sticky, single-ended mode
    to_negedge();
    mode = 2'b10;
    oc = 1'b1;
    to_negedge();
    oc = 1'b0;
    repeat (10) @(posedge clk);
    #1 check_model("R5", 0, 2'b10, 1, 0);
    to_negedge();
    dev_rst_n = 1'b0;
    settle();
    check_model("R5", 1, 2'b10, 0, 0);
    to_negedge();
    dev_rst_n = 1'b1;
    settle();
    check("R5", "run_o after reset pulse", run, 1);

    // R10 R11 warning behaviour
    to_negedge();
    mode = 2'b00;
    ot_warn = 1'b1;
    settle();
    check("R10", "warn_o set", warn, 1);
    check("R11", "pair 1/1 fault_rel_o", fault_rel, 1);
    check("R11", "run during warning", run, 1);
    to_negedge();
    ot_warn = 1'b0;
    settle();
    check("R10", "warn_o held without clear", warn, 1);
    to_negedge();
    ot_warn = 1'b1;
    ot_warn_clr = 1'b1;
    settle();
    check("R10", "set wins over clear", warn, 1);
    to_negedge();
    ot_warn = 1'b0;
    settle();
    check("R10", "warn_o cleared", warn, 0);
    check("R11", "pair 1/0 fault_rel_o", fault_rel, 1);
    to_negedge();
    ot_warn_clr = 1'b0;
    ot_warn = 1'b1;
    dev_rst_n = 1'b0;
    settle();
    check("R11", "warn_o in device reset", warn, 1);
    to_negedge();
    dev_rst_n = 1'b1;
    uv = 3'b100;
    settle();
    check("R11", "warn_o in shutdown", warn, 1);
    check("R11", "pair 0/x fault_rel_o", fault_rel, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule